// File: doc/BRIEF.md
# Addressable RGB LED Chain Serial Driver

This block drives a chain of single-wire addressable RGB LEDs from one output pin. An internal sequencer steps through a latch interval and then through every data bit of every LED in the chain. It reports which LED is active, which bit is being sent and whether that bit is in its high or low part. A palette lookup turns the LED index into a 24-bit colour. An encoder picks the current bit out of that colour and gives the sequencer the length of the current part. A registered output stage drives the pin.

All pulse widths are runtime inputs counted in clock cycles. Each count is the clock frequency times the wanted time. At 100 MHz the usual values are a 28000-cycle latch, high times of 40 and 80 cycles, and low times of 85 and 45 cycles. The chain length and the palette size are parameters. Frames repeat for as long as reset stays low. The timing and palette inputs are expected to stay constant outside reset.

Top module: `ledchain_driver`

## Requirements
- R1: Reset is synchronous and active high. On any clock edge where `rst` is high, the sequencer restarts at the beginning of the latch interval and `led_dout` is low in the following cycle. After the last edge with `rst` high, `led_dout` stays low for `lat_cycles` rising edges and first goes high on the next rising edge.
- R2: A frame is a latch interval, then LEDs 0 to NUM_LEDS-1 in ascending order with 24 bits each, then the next frame's latch interval. Frames repeat without end.
- R3: During the latch interval `led_dout` is low for exactly `lat_cycles` cycles. These cycles add to the low part of the last bit of the previous frame.
- R4: A 0 bit is sent as `hi0_cycles` cycles high followed by `lo0_cycles` cycles low.
- R5: A 1 bit is sent as `hi1_cycles` cycles high followed by `lo1_cycles` cycles low.
- R6: A palette entry holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each LED sends its green byte first, then red, then blue, each byte most significant bit first.
- R7: LED i takes palette entry i mod PAL_N, which is the slice `palette[24*(i mod PAL_N) +: 24]`. PAL_N is a power of two.
- R8: A cycle count of zero on any timing input is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lat_cycles | input | CNT_W | Latch interval length in cycles |
| hi0_cycles | input | CNT_W | High time of a 0 bit in cycles |
| lo0_cycles | input | CNT_W | Low time of a 0 bit in cycles |
| hi1_cycles | input | CNT_W | High time of a 1 bit in cycles |
| lo1_cycles | input | CNT_W | Low time of a 1 bit in cycles |
| palette | input | 24*PAL_N | Packed colour entries, entry k in bits 24k+23 to 24k |
| led_dout | output | 1 | Serial line to the first LED |

## Verification
The only visible output is one pin, so every internal fault shows up as a wrong pin level.

- A miscounted phase changes a pulse width. The edge then comes early or late, one cycle after the phase ends.
- A wrong bit or LED index sends the wrong data bit, and shows within the next bit period.
- A wrong palette slice or byte order corrupts a pulse width somewhere in the first frame.

The pin is compared against a behavioural waveform on every cycle. That waveform is built from the timing inputs and palette. So a divergence is reported in the exact cycle it first appears.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

  localparam int BITS_PER_LED = 24;

  typedef enum logic [0:0] {K_LATCH = 1'b0, K_LED = 1'b1} kind_e;
  typedef enum logic [0:0] {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  // Palette entry is {R,G,B}; the wire order is G,R,B, MSB first.
  function automatic logic wire_bit(input logic [23:0] rgb, input logic [4:0] k);
    logic [23:0] grb;
    grb = {rgb[15:8], rgb[23:16], rgb[7:0]};
    return grb[5'd23 - k];
  endfunction

endpackage

// File: rtl/ledchain_seq.sv
module ledchain_seq
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int CNT_W    = 16,
  localparam int LED_W   = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] lat_len,
  input  logic [CNT_W-1:0] cur_len,
  output kind_e            kind,
  output phase_e           phase,
  output logic [LED_W-1:0] led_idx,
  output logic [4:0]       bit_idx
);

  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_now;
  logic             phase_done;
  logic             bit_last;
  logic             led_last;
  logic             frame_end;

  assign len_now    = eff_len((kind == K_LATCH) ? lat_len : cur_len);
  assign phase_done = (cnt == len_now - CNT_W'(1));
  assign bit_last   = (bit_idx == 5'(BITS_PER_LED - 1));
  assign led_last   = (led_idx == LED_W'(NUM_LEDS - 1));
  assign frame_end  = phase_done && (kind == K_LED) && (phase == PH_LO) && bit_last && led_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind    <= K_LATCH;
      phase   <= PH_HI;
      led_idx <= '0;
      bit_idx <= '0;
      cnt     <= '0;
    end else if (phase_done) begin
      cnt <= '0;
      if (kind == K_LATCH) begin
        kind    <= K_LED;
        phase   <= PH_HI;
        led_idx <= '0;
        bit_idx <= '0;
      end else if (phase == PH_HI) begin
        phase <= PH_LO;
      end else begin
        phase <= PH_HI;
        if (bit_last) begin
          bit_idx <= '0;
          if (led_last) begin
            kind    <= K_LATCH;
            led_idx <= '0;
          end else begin
            led_idx <= led_idx + LED_W'(1);
          end
        end else begin
          bit_idx <= bit_idx + 5'd1;
        end
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (kind == K_LATCH && cnt == '0));

  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (kind == K_LATCH));

  a_r2_latch_exit: assert property (@(posedge clk) disable iff (rst)
    (kind == K_LATCH && phase_done) |=>
      (kind == K_LED && led_idx == '0 && bit_idx == '0 && phase == PH_HI));

  a_r4_hi_then_lo: assert property (@(posedge clk) disable iff (rst)
    (kind == K_LED && phase == PH_HI && phase_done) |=>
      (phase == PH_LO && $stable(bit_idx) && $stable(led_idx)));

  a_r2_index_range: assert property (@(posedge clk) disable iff (rst)
    (32'(led_idx) < NUM_LEDS) && (32'(bit_idx) < BITS_PER_LED));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < len_now);

endmodule

// File: rtl/ledchain_palette.sv
module ledchain_palette #(
  parameter int NUM_LEDS = 2,
  parameter int PAL_N    = 4,
  localparam int LED_W   = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
  localparam int SEL_W   = (PAL_N > 1) ? $clog2(PAL_N) : 1
) (
  input  logic [LED_W-1:0]    led_idx,
  input  logic [24*PAL_N-1:0] palette,
  output logic [23:0]         rgb
);

  logic [23:0]      entry [PAL_N];
  logic [SEL_W-1:0] sel;

  for (genvar g = 0; g < PAL_N; g++) begin : g_unpack
    assign entry[g] = palette[24*g +: 24];
  end

  assign sel = SEL_W'(32'(led_idx) % PAL_N);
  assign rgb = entry[sel];

endmodule

// File: rtl/ledchain_enc.sv
module ledchain_enc
  import ledchain_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  kind_e            kind,
  input  phase_e           phase,
  input  logic [4:0]       bit_idx,
  input  logic [23:0]      rgb,
  input  logic [CNT_W-1:0] hi0_len,
  input  logic [CNT_W-1:0] lo0_len,
  input  logic [CNT_W-1:0] hi1_len,
  input  logic [CNT_W-1:0] lo1_len,
  output logic [CNT_W-1:0] cur_len,
  output logic             pin
);

  logic bit_val;
  logic drive_high;

  assign bit_val    = wire_bit(rgb, bit_idx);
  assign cur_len    = (phase == PH_HI) ? (bit_val ? hi1_len : hi0_len)
                                       : (bit_val ? lo1_len : lo0_len);
  assign drive_high = (kind == K_LED) && (phase == PH_HI);

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= drive_high;
  end

endmodule

// File: rtl/ledchain_driver.sv
module ledchain_driver
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int PAL_N    = 4,
  parameter int CNT_W    = 16,
  localparam int LED_W   = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    lat_cycles,
  input  logic [CNT_W-1:0]    hi0_cycles,
  input  logic [CNT_W-1:0]    lo0_cycles,
  input  logic [CNT_W-1:0]    hi1_cycles,
  input  logic [CNT_W-1:0]    lo1_cycles,
  input  logic [24*PAL_N-1:0] palette,
  output logic                led_dout
);

  kind_e            kind;
  phase_e           phase;
  logic [LED_W-1:0] led_idx;
  logic [4:0]       bit_idx;
  logic [23:0]      rgb;
  logic [CNT_W-1:0] cur_len;

  ledchain_seq #(.NUM_LEDS(NUM_LEDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .lat_len(lat_cycles), .cur_len(cur_len),
    .kind(kind), .phase(phase), .led_idx(led_idx), .bit_idx(bit_idx)
  );

  ledchain_palette #(.NUM_LEDS(NUM_LEDS), .PAL_N(PAL_N)) u_pal (
    .led_idx(led_idx), .palette(palette), .rgb(rgb)
  );

  ledchain_enc #(.CNT_W(CNT_W)) u_enc (
    .clk(clk), .rst(rst), .kind(kind), .phase(phase), .bit_idx(bit_idx),
    .rgb(rgb), .hi0_len(hi0_cycles), .lo0_len(lo0_cycles),
    .hi1_len(hi1_cycles), .lo1_len(lo1_cycles),
    .cur_len(cur_len), .pin(led_dout)
  );

  a_r3_low_in_latch: assert property (@(posedge clk) disable iff (rst)
    (kind == K_LATCH) |=> !led_dout);

  a_r4_high_in_hi_phase: assert property (@(posedge clk) disable iff (rst)
    (kind == K_LED && phase == PH_HI) |=> led_dout);

endmodule

// File: tb/sim_ledchain_driver.sv
module sim_ledchain_driver;

  localparam int NL = 5;
  localparam int PN = 4;
  localparam int CW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [CW-1:0]  lat_cycles, hi0_cycles, lo0_cycles, hi1_cycles, lo1_cycles;
  logic [24*PN-1:0] palette;
  logic           led_dout;

  int total = 0;
  int bad   = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ledchain_driver #(.NUM_LEDS(NL), .PAL_N(PN), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .lat_cycles(lat_cycles), .hi0_cycles(hi0_cycles),
    .lo0_cycles(lo0_cycles), .hi1_cycles(hi1_cycles), .lo1_cycles(lo1_cycles),
    .palette(palette), .led_dout(led_dout)
  );

  function automatic int fix(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: led_dout=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Expected waveform for two frames, built from the requirements.
  task automatic build(input string extra);
    exp_q.delete();
    tag_q.delete();
    for (int fr = 0; fr < 2; fr++) begin
      for (int c = 0; c < fix(lat_cycles); c++) begin
        exp_q.push_back(1'b0);
        tag_q.push_back(fr == 0 ? {"R1 R3", extra} : {"R2 R3", extra});
      end
      for (int led = 0; led < NL; led++) begin
        logic [23:0] rgb;
        rgb = palette[24*(led % PN) +: 24];
        for (int k = 0; k < 24; k++) begin
          bit b;
          int hl, ll;
          if (k < 8)       b = rgb[15 - k];
          else if (k < 16) b = rgb[23 - (k - 8)];
          else             b = rgb[7 - (k - 16)];
          hl = fix(b ? hi1_cycles : hi0_cycles);
          ll = fix(b ? lo1_cycles : lo0_cycles);
          for (int c = 0; c < hl; c++) begin
            exp_q.push_back(1'b1);
            tag_q.push_back({b ? "R5" : "R4", " R6 R7", extra});
          end
          for (int c = 0; c < ll; c++) begin
            exp_q.push_back(1'b0);
            tag_q.push_back({b ? "R5" : "R4", " R6 R7", extra});
          end
        end
      end
    end
  endtask

  task automatic start(input int lat, input int h0, input int l0, input int h1,
                       input int l1, input logic [24*PN-1:0] pal, input string extra);
    @(negedge clk);
    rst = 1'b1;
    lat_cycles = CW'(lat); hi0_cycles = CW'(h0); lo0_cycles = CW'(l0);
    hi1_cycles = CW'(h1);  lo1_cycles = CW'(l1); palette = pal;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(led_dout, 1'b0, "R1 reset state");
    build(extra);
    rst = 1'b0;
  endtask

  task automatic follow(input int n);
    int lim;
    lim = (n == 0 || n > exp_q.size()) ? exp_q.size() : n;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(led_dout, exp_q[i], tag_q[i]);
    end
  endtask

  logic [24*PN-1:0] pal_a, pal_b;

  initial begin
    // Entries {R,G,B}: red, green, blue, green+blue at level 64.
    pal_a = {24'h004040, 24'h000040, 24'h004000, 24'h400000};
    pal_b = {24'hA5C3F0, 24'h0F1E2D, 24'hFF0001, 24'h81807F};

    start(40, 4, 9, 8, 5, pal_a, "");
    follow(0);

    start(25, 3, 12, 9, 6, pal_b, "");
    follow(0);

    // Reset in the middle of a frame.
    start(30, 4, 9, 8, 5, pal_b, "");
    follow(700);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(led_dout, 1'b0, "R1 mid-frame reset");
    rst = 1'b0;
    follow(300);

    // Zero counts clamp to one cycle.
    start(0, 0, 3, 2, 0, pal_b, " R8");
    follow(0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule